// File: doc/BRIEF.md
# Radix-4 Digit Recoder with Glitch-Blocked Multiple Generation

This block sits in front of the carry-save adder of a word-serial radix-4 modular multiplier. At the start of each outer iteration it takes the three overlapping multiplier bits and the two low bits of the partial sum and modulus. From these it forms two signed digits. The first is a Booth digit in {-2..+2} that scales the multiplicand. The second is a reduction digit in {-1, 0, +1, +2} that makes the low two bits of the partial sum vanish modulo 4. Each digit is held as an enable (digit non-zero) and a select (negate, double) pair in rising-edge registers. When a digit is zero its select register keeps its old contents, so the wide select fan-out does not toggle.

On every word cycle the block turns the current multiplicand word and modulus word into their selected multiples. Doubling shifts the word left by one. The bit that leaves the top is kept in a carry-over register and shifted into the next word. Negation inverts the bits, and the +1 of the two's complement is exported as a separate carry-in for the adder. Both multiple words pass through level-sensitive latches that are open only while the clock is low. Combinational ripple from the recoders therefore cannot reach the adder while the clock is high, and the two multiples arrive at the adder together.

Top module: `r4_recode_mult`

## Requirements
- R1: The multiple-control pair for the multiplicand follows the Booth digit d = -2·a[2] + a[1] + a[0] of `a_trip`. The enable `pp_en` is 1 exactly when d ≠ 0. `pp_sel[1]` (negate) is 1 when d < 0, and `pp_sel[0]` (double) is 1 when |d| = 2.
- R2: For an odd `m_low`, the reduction digit q is the unique value of {0, +1, +2, -1} with (s_low + q·m_low) mod 4 = 0. `mm_en` and `mm_sel` encode q in the same way as R1.
- R3: Controls are captured at a rising clock edge only when `dig_ld` is 1. At any edge with `dig_ld` at 0, enables and selects keep their values whatever `a_trip`, `s_low` and `m_low` do.
- R4: When a digit loads as zero, its enable goes to 0 and its select output keeps the value it held before that load.
- R5: With its enable at 0, a multiple word is all zeros. Otherwise it is the input word, doubled when the double bit is set, and then bit-inverted when the negate bit is set.
- R6: When doubling, bit 0 of the multiple takes the top bit of the previous word, as captured at an edge with `word_vld` at 1 while that digit was enabled and doubling. On a word marked `word_first`, 0 is shifted in instead.
- R7: `pp_cin` (`mm_cin`) is 1 exactly when the corresponding enable and negate bits are both 1.
- R8: `pp_word` and `mm_word` change only while the clock is low. During the high phase they keep the value they had at the rising edge.
- R9: While reset is asserted and for two edges after its release, both enables, both selects, both carry-ins and both multiple words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers use the rising edge, output latches are open while low |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dig_ld | input | 1 | Capture new digits at the next rising edge |
| a_trip | input | 3 | Multiplier bits {a(2j+1), a(2j), a(2j-1)} |
| s_low | input | 2 | Two low bits of the partial sum |
| m_low | input | 2 | Two low bits of the modulus (odd) |
| word_vld | input | 1 | A word is presented this cycle |
| word_first | input | 1 | The presented word is word 0 of the operand |
| b_word | input | W | Multiplicand word |
| m_word | input | W | Modulus word |
| pp_word | output | W | Latched multiple of the multiplicand word |
| mm_word | output | W | Latched multiple of the modulus word |
| pp_cin | output | 1 | Two's-complement carry-in for the multiplicand multiple |
| mm_cin | output | 1 | Two's-complement carry-in for the modulus multiple |
| pp_en | output | 1 | Booth digit non-zero |
| pp_sel | output | 2 | Booth select {negate, double} |
| mm_en | output | 1 | Reduction digit non-zero |
| mm_sel | output | 2 | Reduction select {negate, double} |

## Verification
A digit loaded with `dig_ld` shows on the enable, select and carry-in outputs one rising edge later. A word presented in a cycle reaches the multiple outputs at the following falling edge, built from the controls and carry-over that stood after the preceding rising edge. The bench drives inputs just after each rising edge, updates its reference state at that edge, and compares every output in the late low phase. In the high phase it checks that both multiple words still hold the values they had at the end of the previous low phase.

// File: rtl/r4rec_pkg.sv
package r4rec_pkg;

  // select pair for a radix-4 multiple: negate and double
  typedef struct packed {
    logic neg;
    logic dbl;
  } sel_t;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_PP   = 0;
  localparam int unsigned PATH_MM   = 1;

endpackage

// File: rtl/r4_booth_rec.sv
module r4_booth_rec
  import r4rec_pkg::*;
(
  input  logic [2:0] a_trip,
  output logic       en_d,
  output sel_t       sel_d
);

  always_comb begin
    en_d  = 1'b1;
    sel_d = '0;
    unique case (a_trip)
      3'b000, 3'b111: begin en_d = 1'b0; sel_d = '0; end
      3'b001, 3'b010: begin sel_d.neg = 1'b0; sel_d.dbl = 1'b0; end
      3'b011:         begin sel_d.neg = 1'b0; sel_d.dbl = 1'b1; end
      3'b100:         begin sel_d.neg = 1'b1; sel_d.dbl = 1'b1; end
      default:        begin sel_d.neg = 1'b1; sel_d.dbl = 1'b0; end
    endcase
  end

endmodule

// File: rtl/r4_mont_rec.sv
module r4_mont_rec
  import r4rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] s_low,
  input  logic [1:0] m_low,
  output logic       en_d,
  output sel_t       sel_d
);

  logic [3:0] prod;
  logic [1:0] qm;

  // q = -(s * m) mod 4, valid because m*m = 1 mod 4 for odd m
  always_comb begin
    prod  = {2'b00, s_low} * {2'b00, m_low};
    qm    = 2'(~prod[1:0] + 2'd1);
    en_d  = (qm != 2'd0);
    sel_d.neg = (qm == 2'd3);
    sel_d.dbl = (qm == 2'd2);
  end

  // residue check: s + q*m must be 0 mod 4
  logic [3:0] chk_mag;
  logic [3:0] chk_sum;
  always_comb begin
    chk_mag = sel_d.dbl ? {1'b0, m_low, 1'b0} : {2'b00, m_low};
    if (sel_d.neg) chk_mag = 4'(~chk_mag + 4'd1);
    chk_sum = 4'({2'b00, s_low} + (en_d ? chk_mag : 4'd0));
  end

  p_mont_residue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_low[0] |-> (chk_sum[1:0] == 2'b00));

endmodule

// File: rtl/r4_ctl_reg.sv
module r4_ctl_reg
  import r4rec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic en_d,
  input  sel_t sel_d,
  output logic en_q,
  output sel_t sel_q
);

  logic en_n;
  sel_t sel_n;
  logic sel_ce;

  always_comb begin
    sel_ce = ld & en_d;
    en_n   = ld ? en_d : en_q;
    sel_n  = sel_ce ? sel_d : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      en_q  <= en_n;
      sel_q <= sel_n;
    end
  end

  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(en_q) && $stable(sel_q)));

  p_sel_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !en_d) |=> (!en_q && $stable(sel_q)));

endmodule

// File: rtl/r4_mult_gen.sv
module r4_mult_gen
  import r4rec_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_in,
  input  logic         en,
  input  sel_t         sel,
  input  logic         first,
  input  logic         vld,
  output logic [W-1:0] mult_d,
  output logic         cin
);

  logic         co_q;
  logic         co_n;
  logic         co_ce;
  logic         shin;
  logic [W-1:0] shifted;

  always_comb begin
    shin    = first ? 1'b0 : co_q;
    shifted = sel.dbl ? {word_in[W-2:0], shin} : word_in;
    mult_d  = en ? (shifted ^ {W{sel.neg}}) : '0;
    cin     = en & sel.neg;
    co_ce   = vld & en & sel.dbl;
    co_n    = co_ce ? word_in[W-1] : co_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) co_q <= 1'b0;
    else        co_q <= co_n;
  end

  p_zero_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (mult_d == '0));

  p_first_shin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sel.dbl && first) |-> (mult_d[0] == sel.neg));

endmodule

// File: rtl/r4_glitch_latch.sv
module r4_glitch_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // open only during the low clock phase
  always_latch begin
    if (!clk) q <= d;
  end

endmodule

// File: rtl/r4_recode_mult.sv
module r4_recode_mult
  import r4rec_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dig_ld,
  input  logic [2:0]   a_trip,
  input  logic [1:0]   s_low,
  input  logic [1:0]   m_low,
  input  logic         word_vld,
  input  logic         word_first,
  input  logic [W-1:0] b_word,
  input  logic [W-1:0] m_word,
  output logic [W-1:0] pp_word,
  output logic [W-1:0] mm_word,
  output logic         pp_cin,
  output logic         mm_cin,
  output logic         pp_en,
  output logic [1:0]   pp_sel,
  output logic         mm_en,
  output logic [1:0]   mm_sel
);

  localparam int unsigned NP = NUM_PATHS;

  // reset: asserted asynchronously, released on the second rising edge
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic         en_d  [NP];
  sel_t         sel_d [NP];
  logic         en_q  [NP];
  sel_t         sel_q [NP];
  logic [W-1:0] word  [NP];
  logic [W-1:0] mult  [NP];
  logic [W-1:0] mlat  [NP];
  logic         cin   [NP];

  r4_booth_rec u_booth (
    .a_trip (a_trip),
    .en_d   (en_d[PATH_PP]),
    .sel_d  (sel_d[PATH_PP])
  );

  r4_mont_rec u_mont (
    .clk    (clk),
    .rst_n  (rst_s),
    .s_low  (s_low),
    .m_low  (m_low),
    .en_d   (en_d[PATH_MM]),
    .sel_d  (sel_d[PATH_MM])
  );

  assign word[PATH_PP] = b_word;
  assign word[PATH_MM] = m_word;

  for (genvar p = 0; p < NP; p++) begin : g_path
    r4_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_s),
      .ld    (dig_ld),
      .en_d  (en_d[p]),
      .sel_d (sel_d[p]),
      .en_q  (en_q[p]),
      .sel_q (sel_q[p])
    );

    r4_mult_gen #(.W(W)) u_gen (
      .clk     (clk),
      .rst_n   (rst_s),
      .word_in (word[p]),
      .en      (en_q[p]),
      .sel     (sel_q[p]),
      .first   (word_first),
      .vld     (word_vld),
      .mult_d  (mult[p]),
      .cin     (cin[p])
    );

    r4_glitch_latch #(.W(W)) u_lat (
      .clk (clk),
      .d   (mult[p]),
      .q   (mlat[p])
    );
  end

  assign pp_word = mlat[PATH_PP];
  assign mm_word = mlat[PATH_MM];
  assign pp_cin  = cin[PATH_PP];
  assign mm_cin  = cin[PATH_MM];
  assign pp_en   = en_q[PATH_PP];
  assign mm_en   = en_q[PATH_MM];
  assign pp_sel  = sel_q[PATH_PP];
  assign mm_sel  = sel_q[PATH_MM];

  // high-phase hold check on the latched words
  logic [W-1:0] pp_snap;
  logic [W-1:0] mm_snap;
  logic         snap_ok;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pp_snap <= '0;
      mm_snap <= '0;
      snap_ok <= 1'b0;
    end else begin
      pp_snap <= pp_word;
      mm_snap <= mm_word;
      snap_ok <= 1'b1;
    end
  end

  p_latch_hold_r8: assert property (@(negedge clk) disable iff (!rst_s)
    snap_ok |-> ((pp_word == pp_snap) && (mm_word == mm_snap)));

endmodule

// File: tb/r4_recode_mult_tb.sv
module r4_recode_mult_tb;

  localparam int unsigned W      = 16;
  localparam int unsigned CLK_NS = 10;

  logic         clk;
  logic         rst_n;
  logic         dig_ld;
  logic [2:0]   a_trip;
  logic [1:0]   s_low;
  logic [1:0]   m_low;
  logic         word_vld;
  logic         word_first;
  logic [W-1:0] b_word;
  logic [W-1:0] m_word;
  logic [W-1:0] pp_word;
  logic [W-1:0] mm_word;
  logic         pp_cin;
  logic         mm_cin;
  logic         pp_en;
  logic [1:0]   pp_sel;
  logic         mm_en;
  logic [1:0]   mm_sel;

  r4_recode_mult #(.W(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dig_ld     (dig_ld),
    .a_trip     (a_trip),
    .s_low      (s_low),
    .m_low      (m_low),
    .word_vld   (word_vld),
    .word_first (word_first),
    .b_word     (b_word),
    .m_word     (m_word),
    .pp_word    (pp_word),
    .mm_word    (mm_word),
    .pp_cin     (pp_cin),
    .mm_cin     (mm_cin),
    .pp_en      (pp_en),
    .pp_sel     (pp_sel),
    .mm_en      (mm_en),
    .mm_sel     (mm_sel)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int n_chk;
  int n_fail;
  bit done;

  // reference state, index 0 = multiplicand path, 1 = modulus path
  bit           r_en  [2];
  bit           r_neg [2];
  bit           r_dbl [2];
  bit           r_co  [2];
  logic [W-1:0] last_pp;
  logic [W-1:0] last_mm;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int booth_digit(input logic [2:0] a);
    return -2 * int'(a[2]) + int'(a[1]) + int'(a[0]);
  endfunction

  function automatic int mont_digit(input logic [1:0] s, input logic [1:0] m);
    int cand [4] = '{0, 1, 2, -1};
    for (int k = 0; k < 4; k++) begin
      if (((int'(s) + cand[k] * int'(m)) % 4 + 4) % 4 == 0) return cand[k];
    end
    return 99;
  endfunction

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] w, input bit e, input bit n,
                                            input bit d, input bit si);
    logic [W-1:0] v;
    v = d ? ((w << 1) | W'(si)) : w;
    if (n) v = ~v;
    if (!e) v = '0;
    return v;
  endfunction

  // apply the effect of the rising edge that just happened
  task automatic model_edge();
    int dg;
    if (word_vld && r_en[0] && r_dbl[0]) r_co[0] = b_word[W-1];
    if (word_vld && r_en[1] && r_dbl[1]) r_co[1] = m_word[W-1];
    if (dig_ld) begin
      dg = booth_digit(a_trip);
      r_en[0] = (dg != 0);
      if (dg != 0) begin r_neg[0] = (dg < 0); r_dbl[0] = (dg == 2 || dg == -2); end
      dg = mont_digit(s_low, m_low);
      r_en[1] = (dg != 0);
      if (dg != 0) begin r_neg[1] = (dg < 0); r_dbl[1] = (dg == 2 || dg == -2); end
    end
  endtask

  task automatic check_low();
    logic [W-1:0] epp;
    logic [W-1:0] emm;
    epp = exp_word(b_word, r_en[0], r_neg[0], r_dbl[0], word_first ? 1'b0 : r_co[0]);
    emm = exp_word(m_word, r_en[1], r_neg[1], r_dbl[1], word_first ? 1'b0 : r_co[1]);
    chk(pp_word === epp, "R5 R6 pp_word", 64'(pp_word), 64'(epp));
    chk(mm_word === emm, "R5 R6 mm_word", 64'(mm_word), 64'(emm));
    chk(pp_cin === (r_en[0] & r_neg[0]), "R7 pp_cin", 64'(pp_cin), 64'(r_en[0] & r_neg[0]));
    chk(mm_cin === (r_en[1] & r_neg[1]), "R7 mm_cin", 64'(mm_cin), 64'(r_en[1] & r_neg[1]));
    chk(pp_en === r_en[0], "R1 pp_en", 64'(pp_en), 64'(r_en[0]));
    chk(pp_sel === {r_neg[0], r_dbl[0]}, "R1 R4 pp_sel", 64'(pp_sel), 64'({r_neg[0], r_dbl[0]}));
    chk(mm_en === r_en[1], "R2 mm_en", 64'(mm_en), 64'(r_en[1]));
    chk(mm_sel === {r_neg[1], r_dbl[1]}, "R2 R4 mm_sel", 64'(mm_sel), 64'({r_neg[1], r_dbl[1]}));
    last_pp = pp_word;
    last_mm = mm_word;
  endtask

  task automatic step(input bit ld, input logic [2:0] a, input logic [1:0] s, input logic [1:0] m,
                      input bit v, input bit f, input logic [W-1:0] bw, input logic [W-1:0] mw);
    @(posedge clk);
    model_edge();
    #1;
    dig_ld = ld; a_trip = a; s_low = s; m_low = m;
    word_vld = v; word_first = f; b_word = bw; m_word = mw;
    #3;
    chk(pp_word === last_pp, "R8 pp high hold", 64'(pp_word), 64'(last_pp));
    chk(mm_word === last_mm, "R8 mm high hold", 64'(mm_word), 64'(last_mm));
    #5;
    check_low();
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    for (int p = 0; p < 2; p++) begin r_en[p] = 0; r_neg[p] = 0; r_dbl[p] = 0; r_co[p] = 0; end
    last_pp = '0; last_mm = '0;
    rst_n = 1'b0; dig_ld = 1'b1; a_trip = 3'b011; s_low = 2'd2; m_low = 2'd3;
    word_vld = 1'b1; word_first = 1'b0; b_word = 16'hFFFF; m_word = 16'hFFFF;

    // R9: reset state despite active loads
    repeat (3) @(posedge clk);
    #(CLK_NS/2 + 3);
    chk(pp_en === 1'b0 && mm_en === 1'b0, "R9 enables in reset", 64'({pp_en, mm_en}), 64'd0);
    chk(pp_sel === 2'b00 && mm_sel === 2'b00, "R9 selects in reset", 64'({pp_sel, mm_sel}), 64'd0);
    chk(pp_word === '0 && mm_word === '0, "R9 words in reset", 64'({pp_word, mm_word}), 64'd0);
    chk(pp_cin === 1'b0 && mm_cin === 1'b0, "R9 cin in reset", 64'({pp_cin, mm_cin}), 64'd0);
    @(posedge clk);
    #1;
    dig_ld = 1'b0; word_vld = 1'b0; rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 R2: every multiplier triple with every sum residue, both odd moduli
    for (int mi = 0; mi < 2; mi++) begin
      for (int a = 0; a < 8; a++) begin
        for (int s = 0; s < 4; s++) begin
          step(1'b1, 3'(a), 2'(s), mi ? 2'd3 : 2'd1, 1'b0, 1'b1, 16'($urandom), 16'($urandom));
        end
      end
    end
    step(1'b0, 3'b000, 2'd0, 2'd1, 1'b0, 1'b1, 16'h1234, 16'h5678);

    // R6: multi-word doubling chains, positive and negative
    for (int run = 0; run < 4; run++) begin
      step(1'b1, run[0] ? 3'b100 : 3'b011, 2'd2, run[1] ? 2'd3 : 2'd1, 1'b0, 1'b1, '0, '0);
      for (int k = 0; k < 6; k++) begin
        step(1'b0, 3'($urandom), 2'($urandom), 2'd1, 1'b1, (k == 0),
             16'($urandom), 16'($urandom));
      end
    end
    // R6: word with top bit set then a first word: shift-in must be 0
    step(1'b0, 3'b000, 2'd0, 2'd1, 1'b1, 1'b0, 16'h8000, 16'h8001);
    step(1'b0, 3'b000, 2'd0, 2'd1, 1'b1, 1'b1, 16'h0001, 16'h0001);
    chk(pp_word[0] === pp_sel[1], "R6 first word shift-in", 64'(pp_word[0]), 64'(pp_sel[1]));

    // R3: no load, digit inputs wiggle, controls unchanged
    step(1'b1, 3'b001, 2'd1, 2'd1, 1'b0, 1'b1, 16'h00F0, 16'h0F00);
    step(1'b0, 3'b100, 2'd2, 2'd3, 1'b0, 1'b1, 16'h00F0, 16'h0F00);
    step(1'b0, 3'b011, 2'd3, 2'd1, 1'b0, 1'b1, 16'h00F0, 16'h0F00);
    chk(pp_en === 1'b1 && pp_sel === 2'b00, "R3 booth ctl held", 64'({pp_en, pp_sel}), 64'b100);
    chk(mm_en === 1'b1 && mm_sel === 2'b10, "R3 mont ctl held", 64'({mm_en, mm_sel}), 64'b110);

    // R4: load doubling digits, then zero digits; selects stay frozen
    step(1'b1, 3'b011, 2'd2, 2'd1, 1'b0, 1'b1, 16'h0F0F, 16'hF0F0);
    step(1'b1, 3'b111, 2'd0, 2'd3, 1'b0, 1'b1, 16'h0F0F, 16'hF0F0);
    step(1'b0, 3'b111, 2'd0, 2'd3, 1'b0, 1'b1, 16'h0F0F, 16'hF0F0);
    chk(pp_en === 1'b0 && pp_sel === 2'b01, "R4 booth sel frozen", 64'({pp_en, pp_sel}), 64'b001);
    chk(mm_en === 1'b0 && mm_sel === 2'b01, "R4 mont sel frozen", 64'({mm_en, mm_sel}), 64'b001);
    chk(pp_word === '0 && mm_word === '0, "R5 zero when disabled", 64'({pp_word, mm_word}), 64'd0);

    // R7: negative single multiple gives carry-in
    step(1'b1, 3'b110, 2'd1, 2'd1, 1'b0, 1'b1, 16'h0003, 16'h0005);
    step(1'b0, 3'b000, 2'd0, 2'd1, 1'b0, 1'b1, 16'h0003, 16'h0005);
    chk(pp_cin === 1'b1 && pp_word === 16'hFFFC, "R7 negate carry-in", 64'({pp_cin, pp_word}), 64'h1FFFC);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule